// File: doc/BRIEF.md
# Output Fault Supervisor with Power-Good and Reverse-Current Retry

This block watches the regulated output of a synchronous buck stage. It takes only digital comparator results and a few control flags. The thresholds and comparators are analog and live elsewhere; this block holds the timing and the state. A rise beyond the upper limit that lasts for the deglitch time latches the low-side switch on. A deep sag that lasts as long latches both gate drivers into high impedance. Either latch shuts the controller down. Only dropping the enable or the supply-good flag releases a latch.

The block also produces an open-drain power-good pull-down. Power-good is released only when all of these hold: the block is enabled, soft-start has finished, no fault is latched, and the window comparator has reported "inside" for the full filter time. Every change of the window input must persist for the filter time before the filtered state follows it.

A reverse-current flag can arrive while the low side is conducting. The block then blocks the low side for a wait time and forces it on for a short re-sense pulse. It repeats this loop while the flag is still present at the end of a pulse. All times are given in nanoseconds and converted to clock cycles with a clock-frequency parameter, rounding up. A count is never less than one cycle. The control and status pins are plain levels, with no handshake.

Top module: `out_fault_supervisor`

## Requirements
- R1: With the block active, `ov_i` held high for DG consecutive sampled cycles sets `force_ls_on_o` and `ctrl_off_o` at the DG-th edge. A pulse of DG-1 cycles or fewer latches nothing. DG = ceil(DEGLITCH_NS*CLK_MHZ/1000).
- R2: With the block active and `ss_done_i` high, `uv_i` held high for DG consecutive cycles sets `tristate_o` and `ctrl_off_o`. Before soft-start is done, `uv_i` is ignored for any duration.
- R3: A latched fault remains after its comparator input returns low. It clears only when `en_i` or `supply_ok_i` is sampled low for at least one cycle.
- R4: If both fault inputs qualify in the same cycle, the over-voltage latch wins: `force_ls_on_o`=1 and `tristate_o`=0.
- R5: `pg_pull_low_o` is 1 whenever the block is inactive, `ss_done_i` is low, a fault is latched, or the filtered window state is "outside".
- R6: The filtered window state follows `pg_win_i` (1 = inside ±10%) only after DG consecutive cycles of disagreement, in both directions. It starts "outside" after enable. Shorter excursions leave `pg_pull_low_o` unchanged.
- R7: When `ls_on_i` and `neg_oc_i` are both sampled high, `ls_block_o` is 1 for exactly WT cycles. `ls_pulse_o` is then 1 for exactly RS cycles. WT = ceil(RETRY_WAIT_NS*CLK_MHZ/1000) and RS = ceil(RESENSE_NS*CLK_MHZ/1000).
- R8: If `neg_oc_i` is high at the last cycle of the re-sense pulse, a new wait begins; otherwise both overrides return to 0. A fault latch aborts the loop at once.
- R9: While `en_i` or `supply_ok_i` is low, `tristate_o`=1 and `force_ls_on_o`, `ctrl_off_o`, `ls_block_o` and `ls_pulse_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable request |
| supply_ok_i | input | 1 | Analog supply above its lockout level |
| ss_done_i | input | 1 | Soft-start finished |
| ov_i | input | 1 | Output above +10% of set point |
| uv_i | input | 1 | Output below -30% of set point |
| pg_win_i | input | 1 | Output inside the ±10% window |
| ls_on_i | input | 1 | Low-side switch currently commanded on |
| neg_oc_i | input | 1 | Phase node above the reverse-current threshold |
| pg_pull_low_o | output | 1 | 1 = pull the power-good pin low |
| force_ls_on_o | output | 1 | Latch low-side switch on (over-voltage) |
| tristate_o | output | 1 | Put both gate drivers in high impedance |
| ctrl_off_o | output | 1 | Controller latched off by a fault |
| ls_block_o | output | 1 | Hold low side off during the retry wait |
| ls_pulse_o | output | 1 | Force low side on for the re-sense pulse |

## Verification
A wrong latch state reaches the driver pins in the same cycle, because those pins decode the latch register directly. A deglitch counter that restarts or saturates wrongly moves the latch or power-good edge by one or more cycles. The sweeps over every sub-threshold pulse width expose that. A faulty retry state machine shows up as a block or pulse window of the wrong length, or as a loop that fails to repeat or to stop. Each of these is visible within one wait-plus-pulse period.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

  typedef enum logic [1:0] {
    LATCH_NONE = 2'd0,
    LATCH_OV   = 2'd1,
    LATCH_UV   = 2'd2
  } latch_t;

  typedef enum logic [1:0] {
    NR_IDLE  = 2'd0,
    NR_WAIT  = 2'd1,
    NR_SENSE = 2'd2
  } nr_t;

  // nanoseconds to clock cycles, rounded up, at least one
  function automatic int ns_to_cycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ofs_persist.sv
module ofs_persist #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic level,
  output logic qual
);
  localparam int W = $clog2(N + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !level) begin
      cnt <= '0;
    end else if (cnt != W'(N - 1)) begin
      cnt <= cnt + 1'b1;
    end
  end

  // qualifies on the N-th consecutive sampled cycle of the level
  assign qual = level && !clr && (cnt == W'(N - 1));

endmodule

// File: rtl/ofs_pg_filter.sv
module ofs_pg_filter #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic win_i,
  output logic filt_o
);
  localparam int W = $clog2(N + 1);

  logic [W-1:0] cnt;
  logic         filt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt    <= '0;
      filt_q <= 1'b0;
    end else if (win_i == filt_q) begin
      cnt <= '0;
    end else if (cnt == W'(N - 1)) begin
      filt_q <= win_i;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign filt_o = filt_q;

  // R6
  filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> $past(win_i));

endmodule

// File: rtl/ofs_negoc_retry.sv
module ofs_negoc_retry
  import ofs_pkg::*;
#(
  parameter int WAIT_N = 4,
  parameter int RES_N  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ls_on_i,
  input  logic neg_oc_i,
  output logic block_o,
  output logic pulse_o
);
  localparam int MAXN = (WAIT_N > RES_N) ? WAIT_N : RES_N;
  localparam int W    = $clog2(MAXN + 1);

  nr_t          st;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st  <= NR_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        NR_IDLE: begin
          cnt <= '0;
          if (ls_on_i && neg_oc_i) st <= NR_WAIT;
        end
        NR_WAIT: begin
          if (cnt == W'(WAIT_N - 1)) begin
            st  <= NR_SENSE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        NR_SENSE: begin
          if (cnt == W'(RES_N - 1)) begin
            st  <= neg_oc_i ? NR_WAIT : NR_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= NR_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign block_o = (st == NR_WAIT);
  assign pulse_o = (st == NR_SENSE);

  // R7
  pulse_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(block_o));

  // R8
  block_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_o) |-> $past(neg_oc_i));

endmodule

// File: rtl/out_fault_supervisor.sv
module out_fault_supervisor
  import ofs_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int DEGLITCH_NS   = 5000,
  parameter int RETRY_WAIT_NS = 2500,
  parameter int RESENSE_NS    = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic supply_ok_i,
  input  logic ss_done_i,
  input  logic ov_i,
  input  logic uv_i,
  input  logic pg_win_i,
  input  logic ls_on_i,
  input  logic neg_oc_i,
  output logic pg_pull_low_o,
  output logic force_ls_on_o,
  output logic tristate_o,
  output logic ctrl_off_o,
  output logic ls_block_o,
  output logic ls_pulse_o
);
  localparam int DG = ns_to_cycles(DEGLITCH_NS, CLK_MHZ);
  localparam int WT = ns_to_cycles(RETRY_WAIT_NS, CLK_MHZ);
  localparam int RS = ns_to_cycles(RESENSE_NS, CLK_MHZ);

  logic   active;
  logic   ov_qual, uv_qual;
  logic   pg_filt;
  logic   faulted;
  logic   nr_block, nr_pulse;
  latch_t latch_q;

  assign active = en_i && supply_ok_i;

  ofs_persist #(.N(DG)) u_ov_dg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .level (ov_i),
    .qual  (ov_qual)
  );

  ofs_persist #(.N(DG)) u_uv_dg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active),
    .level (uv_i && ss_done_i),
    .qual  (uv_qual)
  );

  // fault latch: over-voltage checked first, first latch holds
  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      latch_q <= LATCH_NONE;
    end else if (latch_q == LATCH_NONE) begin
      if (ov_qual)      latch_q <= LATCH_OV;
      else if (uv_qual) latch_q <= LATCH_UV;
    end
  end

  assign faulted = (latch_q != LATCH_NONE);

  ofs_pg_filter #(.N(DG)) u_pg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!active),
    .win_i  (pg_win_i),
    .filt_o (pg_filt)
  );

  ofs_negoc_retry #(.WAIT_N(WT), .RES_N(RS)) u_nr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!active || faulted),
    .ls_on_i  (ls_on_i),
    .neg_oc_i (neg_oc_i),
    .block_o  (nr_block),
    .pulse_o  (nr_pulse)
  );

  assign force_ls_on_o = active && (latch_q == LATCH_OV);
  assign tristate_o    = !active || (latch_q == LATCH_UV);
  assign ctrl_off_o    = active && faulted;
  assign ls_block_o    = active && !faulted && nr_block;
  assign ls_pulse_o    = active && !faulted && nr_pulse;
  assign pg_pull_low_o = !(active && ss_done_i && pg_filt && !faulted);

  // R1
  ov_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_ls_on_o) |-> $past(ov_i));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_off_o && en_i && supply_ok_i) |=> (ctrl_off_o || !(en_i && supply_ok_i)));

  // R4
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_ls_on_o && tristate_o));

endmodule

// File: tb/out_fault_supervisor_test.sv
module out_fault_supervisor_test;
  localparam int PERIOD  = 10;
  localparam int MHZ     = 4;
  localparam int DG      = (5000 * MHZ + 999) / 1000;
  localparam int WT      = (2500 * MHZ + 999) / 1000;
  localparam int RS      = (300 * MHZ + 999) / 1000;

  logic clk = 0;
  logic rst_n, en, sok, ssd, ov, uv, win, lson, noc;
  logic pgl, fls, tri_s, coff, blk, pls;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  out_fault_supervisor #(.CLK_MHZ(MHZ)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(sok), .ss_done_i(ssd),
    .ov_i(ov), .uv_i(uv), .pg_win_i(win), .ls_on_i(lson), .neg_oc_i(noc),
    .pg_pull_low_o(pgl), .force_ls_on_o(fls), .tristate_o(tri_s),
    .ctrl_off_o(coff), .ls_block_o(blk), .ls_pulse_o(pls)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart();
    en = 0; ov = 0; uv = 0; win = 0; lson = 0; noc = 0; ssd = 0;
    tick(2);
    en = 1; sok = 1;
    tick(1);
  endtask

  task automatic measure(input bit which, output int n);
    n = 0;
    while (((which ? pls : blk) == 1'b1) && n < 1000) begin
      n++;
      tick(1);
    end
  endtask

  initial begin
    tick(200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; en = 0; sok = 0; ssd = 0; ov = 0; uv = 0; win = 0; lson = 0; noc = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    // R9 reset and disabled state
    chk("R9 tristate", tri_s, 1);
    chk("R9 force", fls, 0);
    chk("R9 ctrl_off", coff, 0);
    chk("R5 pg low when disabled", pgl, 1);

    // R1 sub-threshold over-voltage sweep
    restart();
    for (int l = 1; l < DG; l++) begin
      ov = 1; tick(l); ov = 0; tick(2);
      chk("R1 short ov ignored", fls, 0);
    end
    ov = 1; tick(DG - 1);
    chk("R1 not yet latched", fls, 0);
    tick(1);
    chk("R1 force_ls_on", fls, 1);
    chk("R1 ctrl_off", coff, 1);
    chk("R1 no tristate", tri_s, 0);
    // R3 holds after ov clears
    ov = 0; tick(3 * DG);
    chk("R3 ov latch held", fls, 1);
    sok = 0; tick(1);
    chk("R9 force off while supply low", fls, 0);
    chk("R9 tristate while supply low", tri_s, 1);
    sok = 1; tick(1);
    chk("R3 cleared by supply toggle", coff, 0);

    // R2 uv ignored before soft-start done
    restart();
    uv = 1; tick(3 * DG);
    chk("R2 uv ignored before ss_done", tri_s, 0);
    uv = 0; ssd = 1; tick(1);
    for (int l = 1; l < DG; l++) begin
      uv = 1; tick(l); uv = 0; tick(2);
      chk("R2 short uv ignored", tri_s, 0);
    end
    uv = 1; tick(DG - 1);
    chk("R2 not yet latched", tri_s, 0);
    tick(1);
    chk("R2 tristate", tri_s, 1);
    chk("R2 ctrl_off", coff, 1);
    chk("R2 no force", fls, 0);
    uv = 0; tick(2 * DG);
    chk("R3 uv latch held", tri_s, 1);
    en = 0; tick(1); en = 1; tick(1);
    chk("R3 cleared by enable toggle", tri_s, 0);
    chk("R3 ctrl_off cleared", coff, 0);

    // R4 simultaneous faults
    restart();
    ssd = 1; ov = 1; uv = 1; tick(DG);
    chk("R4 ov wins force", fls, 1);
    chk("R4 ov wins no tristate", tri_s, 0);
    chk("R5 pg low on fault", pgl, 1);

    // R6 power-good filter
    restart();
    win = 1; ssd = 1; tick(DG - 1);
    chk("R6 pg held during rise filter", pgl, 1);
    tick(1);
    chk("R6 pg released after DG", pgl, 0);
    ssd = 0; tick(1);
    chk("R5 pg low without ss_done", pgl, 1);
    ssd = 1; tick(1);
    for (int l = 1; l < DG; l++) begin
      win = 0; tick(l); win = 1; tick(2);
      chk("R6 short excursion ignored", pgl, 0);
    end
    win = 0; tick(DG - 1);
    chk("R6 pg still released", pgl, 0);
    tick(1);
    chk("R6 pg low after DG outside", pgl, 1);
    win = 1; tick(DG - 1);
    chk("R6 pg held on return", pgl, 1);
    tick(1);
    chk("R6 pg released on return", pgl, 0);

    // R7 / R8 reverse-current retry
    restart();
    lson = 1; noc = 1; tick(1);
    chk("R7 block starts", blk, 1);
    measure(0, n);
    chk("R7 wait length", n, WT);
    chk("R7 pulse follows", pls, 1);
    measure(1, n);
    chk("R7 pulse length", n, RS);
    chk("R8 repeats while flagged", blk, 1);
    noc = 0; lson = 0;
    measure(0, n);
    chk("R8 second wait length", n, WT);
    measure(1, n);
    chk("R8 second pulse length", n, RS);
    tick(2);
    chk("R8 loop stops block", blk, 0);
    chk("R8 loop stops pulse", pls, 0);

    // R8 abort by ov latch
    lson = 1; noc = 1; tick(1);
    lson = 0; ov = 1; tick(DG);
    chk("R8 abort force", fls, 1);
    chk("R8 abort block", blk, 0);
    chk("R8 abort pulse", pls, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule